// File: doc/BRIEF.md
# Host Memory Access Port Slave

This block gives an external host read access to a processor's internal program and data memories over a 16-bit bus that carries both addresses and data. The host sets up a target with an address-latch strobe: the control word it drives names a memory and a start address. It then runs read cycles with active-low select and read strobes, and the port raises its active-low acknowledge line while it fetches. The address steps forward after every complete word.

Reads are short reads, which makes the port a one-word prefetch buffer. When acknowledge rises, the bus already shows the word fetched by the previous read. The word being fetched now replaces that buffer only when acknowledge falls again. For this reason, the first read after a new address is a dummy read.

Program words are 24 bits wide and travel as two bus halves. If the control register is reloaded between the two halves, by a host latch or by a core-side write, the pending half is dropped. The next host write cycle then loads the control register. The memories are modelled as synchronous RAMs with a core-side write port.

Top module: `hmap_port`

## Requirements
- R1: While reset is held and after it is released, the acknowledge output is low, the bus output word is zero and the bus output enable is low.
- R2: A read that is accepted on a clock edge drives acknowledge high from that edge for exactly FETCH_LAT cycles, after which it returns low.
- R3: The bus output enable is high exactly while select and read are both low. While acknowledge is high, the bus output stays unchanged and shows the previously fetched word.
- R4: The first read after the control register is loaded returns the stale buffer contents, which is zero after reset. Each later read returns the word fetched by the read before it.
- R5: In data memory, each read fetches the word at the current address and then adds 1 to the address. The address wraps modulo 2^14, and the memory index is the low address bits.
- R6: In program memory, the first half returns word bits 23:8 and the second half returns bits 7:0 in bus bits 15:8 with bits 7:0 zero. The address advances only after the second half.
- R7: A new read is accepted only while acknowledge is low and only after the strobes of the previous cycle have been released. Holding select and read low after the fetch completes starts no further fetch.
- R8: The control word has bit 14 set for data memory and clear for program memory. Bits 13:0 hold the start address and bit 15 is ignored. A one-cycle address-latch strobe and a core control write both load it. When both occur in the same cycle, the core write wins.
- R9: A control load that happens while a program-word second half is pending drops that half. The next host write cycle (select and write low) then loads its bus word into the control register.
- R10: A host write cycle while no such loss is pending has no effect on address, memory select or returned data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel_n | input | 1 | Host select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_latch | input | 1 | Address-latch strobe, active high |
| host_ad_in | input | BUS_W | Bus word driven by the host |
| host_ad_out | output | BUS_W | Output buffer word |
| host_ad_oe | output | 1 | Bus drive enable for host_ad_out |
| host_ack_n | output | 1 | Acknowledge, high while a fetch is in progress |
| core_ctl_we | input | 1 | Core-side control register write |
| core_ctl_wdata | input | BUS_W | Core-side control word |
| core_mem_we | input | 1 | Core-side memory write enable |
| core_mem_pm | input | 1 | Core write targets program memory when high |
| core_mem_addr | input | ADDR_W | Core write address |
| core_mem_wdata | input | PM_W | Core write data (low BUS_W bits used for data memory) |

## Verification
The bench builds the port with 16-word program and data memories and a three-cycle fetch. At that size a few dozen reads sweep every location of both memories, and the multi-cycle acknowledge window has room to be counted and held. A start address just below 2^14 exercises the 14-bit address wrap together with the index wrap of the small memories. Program-word loss is driven through both the host latch and the core write, each followed by a capturing host write and by a later write that must be ignored.

// File: rtl/hmap_pkg.sv
package hmap_pkg;
   typedef enum logic [1:0] {
      KIND_DM    = 2'd0,
      KIND_PM_HI = 2'd1,
      KIND_PM_LO = 2'd2
   } hmap_kind_e;
endpackage

// File: rtl/hmap_ram.sv
module hmap_ram #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 64,
   localparam int IW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [IW-1:0]    wr_idx,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   input  logic [IW-1:0]    rd_idx,
   output logic [WIDTH-1:0] rd_data
);
   logic [WIDTH-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) cells[wr_idx] <= wr_data;
      if (rd_en) rd_data <= cells[rd_idx];
   end
endmodule

// File: rtl/hmap_ctl_reg.sv
module hmap_ctl_reg #(
   parameter int BUS_W  = 16,
   parameter int ADDR_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_sel_n,
   input  logic              host_wr_n,
   input  logic              host_latch,
   input  logic [BUS_W-1:0]  host_ad_in,
   input  logic              core_ctl_we,
   input  logic [BUS_W-1:0]  core_ctl_wdata,
   input  logic              fetch_go,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              cur_dm,
   output logic              half_pend,
   output logic              cap_pend
);
   logic             wr_act, wr_prev, wr_go;
   logic             ctl_load, loss;
   logic [BUS_W-1:0] ctl_word;
   logic             unused_hi;

   assign wr_act = !host_sel_n && !host_wr_n;
   assign wr_go  = wr_act && !wr_prev;
   assign loss   = (core_ctl_we || host_latch) && half_pend;

   always_comb begin
      ctl_load = 1'b1;
      ctl_word = core_ctl_wdata;
      if (core_ctl_we)             ctl_word = core_ctl_wdata;
      else if (host_latch)         ctl_word = host_ad_in;
      else if (wr_go && cap_pend)  ctl_word = host_ad_in;
      else                         ctl_load = 1'b0;
   end

   assign unused_hi = ^ctl_word[BUS_W-1:ADDR_W+1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_prev   <= 1'b0;
         cur_addr  <= '0;
         cur_dm    <= 1'b0;
         half_pend <= 1'b0;
         cap_pend  <= 1'b0;
      end else begin
         wr_prev <= wr_act;
         if (ctl_load) begin
            cur_addr  <= ctl_word[ADDR_W-1:0];
            cur_dm    <= ctl_word[ADDR_W];
            half_pend <= 1'b0;
         end else if (fetch_go) begin
            if (cur_dm || half_pend) cur_addr <= cur_addr + 1'b1;
            if (!cur_dm) half_pend <= !half_pend;
         end
         if (loss)                    cap_pend <= 1'b1;
         else if (wr_go && cap_pend)  cap_pend <= 1'b0;
      end
   end
endmodule

// File: rtl/hmap_rd_seq.sv
module hmap_rd_seq
   import hmap_pkg::*;
#(
   parameter int BUS_W     = 16,
   parameter int PM_W      = 24,
   parameter int FETCH_LAT = 2,
   localparam int LO_W     = PM_W - BUS_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_sel_n,
   input  logic             host_rd_n,
   input  logic             cur_dm,
   input  logic             half_pend,
   input  logic [PM_W-1:0]  pm_rdata,
   input  logic [BUS_W-1:0] dm_rdata,
   output logic             fetch_go,
   output logic             pm_re,
   output logic             dm_re,
   output hmap_kind_e       kind_q,
   output logic [BUS_W-1:0] obuf_q,
   output logic             busy_q
);
   logic             rd_act, rd_prev, done;
   logic [LO_W-1:0]  lo_q;
   logic [BUS_W-1:0] lo_word;

   assign rd_act   = !host_sel_n && !host_rd_n;
   assign fetch_go = rd_act && !rd_prev && !busy_q;
   assign pm_re    = fetch_go && !cur_dm && !half_pend;
   assign dm_re    = fetch_go && cur_dm;

   if (LO_W < BUS_W) begin : g_pad
      assign lo_word = {lo_q, {(BUS_W-LO_W){1'b0}}};
   end else begin : g_full
      assign lo_word = lo_q;
   end

   if (FETCH_LAT == 1) begin : g_one
      assign done = busy_q;
   end else begin : g_multi
      localparam int CW = $clog2(FETCH_LAT);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                         cnt_q <= '0;
         else if (fetch_go)                  cnt_q <= CW'(FETCH_LAT-1);
         else if (busy_q && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
      end
      assign done = busy_q && (cnt_q == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_prev <= 1'b0;
         busy_q  <= 1'b0;
         kind_q  <= KIND_DM;
         obuf_q  <= '0;
         lo_q    <= '0;
      end else begin
         rd_prev <= rd_act;
         if (fetch_go) begin
            busy_q <= 1'b1;
            kind_q <= cur_dm ? KIND_DM : (half_pend ? KIND_PM_LO : KIND_PM_HI);
         end else if (done) begin
            busy_q <= 1'b0;
            case (kind_q)
               KIND_DM:    obuf_q <= dm_rdata;
               KIND_PM_HI: begin
                  obuf_q <= pm_rdata[PM_W-1 -: BUS_W];
                  lo_q   <= pm_rdata[LO_W-1:0];
               end
               default:    obuf_q <= lo_word;
            endcase
         end
      end
   end
endmodule

// File: rtl/hmap_port.sv
module hmap_port
   import hmap_pkg::*;
#(
   parameter int BUS_W     = 16,
   parameter int ADDR_W    = 14,
   parameter int PM_W      = 24,
   parameter int PM_DEPTH  = 64,
   parameter int DM_DEPTH  = 64,
   parameter int FETCH_LAT = 2,
   localparam int PM_IW    = $clog2(PM_DEPTH),
   localparam int DM_IW    = $clog2(DM_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_sel_n,
   input  logic              host_rd_n,
   input  logic              host_wr_n,
   input  logic              host_latch,
   input  logic [BUS_W-1:0]  host_ad_in,
   output logic [BUS_W-1:0]  host_ad_out,
   output logic              host_ad_oe,
   output logic              host_ack_n,
   input  logic              core_ctl_we,
   input  logic [BUS_W-1:0]  core_ctl_wdata,
   input  logic              core_mem_we,
   input  logic              core_mem_pm,
   input  logic [ADDR_W-1:0] core_mem_addr,
   input  logic [PM_W-1:0]   core_mem_wdata
);
   if (FETCH_LAT < 1) begin : g_bad_lat
      $error("hmap_port: FETCH_LAT must be at least 1");
   end
   if (BUS_W < ADDR_W + 2) begin : g_bad_bus
      $error("hmap_port: BUS_W must hold the address, the select bit and a spare bit");
   end
   if (PM_W <= BUS_W || PM_W > 2*BUS_W) begin : g_bad_pm
      $error("hmap_port: PM_W must fit in two bus halves");
   end
   if (PM_DEPTH < 2 || (1 << PM_IW) != PM_DEPTH || PM_IW > ADDR_W) begin : g_bad_pmd
      $error("hmap_port: PM_DEPTH must be a power of two within the address range");
   end
   if (DM_DEPTH < 2 || (1 << DM_IW) != DM_DEPTH || DM_IW > ADDR_W) begin : g_bad_dmd
      $error("hmap_port: DM_DEPTH must be a power of two within the address range");
   end

   logic [ADDR_W-1:0] cur_addr;
   logic              cur_dm, half_pend, cap_pend;
   logic              fetch_go, pm_re, dm_re, busy_q;
   hmap_kind_e        kind_q;
   logic [PM_W-1:0]   pm_rdata;
   logic [BUS_W-1:0]  dm_rdata, obuf_q;
   logic              unused_top;

   assign unused_top = ^{cur_addr, core_mem_addr};

   hmap_ctl_reg #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_ctl (
      .clk(clk), .rst_n(rst_n),
      .host_sel_n(host_sel_n), .host_wr_n(host_wr_n), .host_latch(host_latch),
      .host_ad_in(host_ad_in), .core_ctl_we(core_ctl_we), .core_ctl_wdata(core_ctl_wdata),
      .fetch_go(fetch_go), .cur_addr(cur_addr), .cur_dm(cur_dm),
      .half_pend(half_pend), .cap_pend(cap_pend)
   );

   hmap_rd_seq #(.BUS_W(BUS_W), .PM_W(PM_W), .FETCH_LAT(FETCH_LAT)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .host_sel_n(host_sel_n), .host_rd_n(host_rd_n),
      .cur_dm(cur_dm), .half_pend(half_pend),
      .pm_rdata(pm_rdata), .dm_rdata(dm_rdata),
      .fetch_go(fetch_go), .pm_re(pm_re), .dm_re(dm_re),
      .kind_q(kind_q), .obuf_q(obuf_q), .busy_q(busy_q)
   );

   hmap_ram #(.WIDTH(PM_W), .DEPTH(PM_DEPTH)) u_pm (
      .clk(clk),
      .wr_en(core_mem_we && core_mem_pm), .wr_idx(core_mem_addr[PM_IW-1:0]),
      .wr_data(core_mem_wdata),
      .rd_en(pm_re), .rd_idx(cur_addr[PM_IW-1:0]), .rd_data(pm_rdata)
   );

   hmap_ram #(.WIDTH(BUS_W), .DEPTH(DM_DEPTH)) u_dm (
      .clk(clk),
      .wr_en(core_mem_we && !core_mem_pm), .wr_idx(core_mem_addr[DM_IW-1:0]),
      .wr_data(core_mem_wdata[BUS_W-1:0]),
      .rd_en(dm_re), .rd_idx(cur_addr[DM_IW-1:0]), .rd_data(dm_rdata)
   );

   assign host_ad_out = obuf_q;
   assign host_ad_oe  = !host_sel_n && !host_rd_n;
   assign host_ack_n  = busy_q;
endmodule

// File: rtl/hmap_port_chk.sv
module hmap_port_chk
   import hmap_pkg::*;
#(
   parameter int BUS_W     = 16,
   parameter int PM_W      = 24,
   parameter int FETCH_LAT = 2,
   localparam int PAD_W    = BUS_W - (PM_W - BUS_W),
   localparam logic [BUS_W-1:0] PAD_MASK = BUS_W'((64'd1 << PAD_W) - 64'd1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_sel_n,
   input logic             host_rd_n,
   input logic             host_ack_n,
   input logic [BUS_W-1:0] host_ad_out,
   input hmap_kind_e       kind_q
);
   int unsigned hi_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)          hi_cnt <= 0;
      else if (host_ack_n) hi_cnt <= hi_cnt + 1;
      else                 hi_cnt <= 0;
   end

   assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (!host_ack_n && host_ad_out == '0));

   assert_fetch_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
      host_ack_n |-> (hi_cnt < FETCH_LAT));

   assert_fetch_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_ack_n && hi_cnt != 0) |-> (hi_cnt == FETCH_LAT));

   assert_buf_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      host_ack_n |-> $stable(host_ad_out));

   assert_rise_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_ack_n) |-> $past(!host_sel_n && !host_rd_n));

   assert_low_pad_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(host_ack_n) && kind_q == KIND_PM_LO) |-> ((host_ad_out & PAD_MASK) == '0));
endmodule

bind hmap_port hmap_port_chk #(.BUS_W(BUS_W), .PM_W(PM_W), .FETCH_LAT(FETCH_LAT)) u_chk (
   .clk(clk), .rst_n(rst_n), .host_sel_n(host_sel_n), .host_rd_n(host_rd_n),
   .host_ack_n(host_ack_n), .host_ad_out(host_ad_out), .kind_q(kind_q)
);

// File: tb/test_hmap_port.sv
`timescale 1ns/1ps
module test_hmap_port;
   localparam int BUS_W = 16, ADDR_W = 14, PM_W = 24, DEPTH = 16, LAT = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              host_sel_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1, host_latch = 1'b0;
   logic [BUS_W-1:0]  host_ad_in = '0;
   logic [BUS_W-1:0]  host_ad_out;
   logic              host_ad_oe, host_ack_n;
   logic              core_ctl_we = 1'b0;
   logic [BUS_W-1:0]  core_ctl_wdata = '0;
   logic              core_mem_we = 1'b0, core_mem_pm = 1'b0;
   logic [ADDR_W-1:0] core_mem_addr = '0;
   logic [PM_W-1:0]   core_mem_wdata = '0;

   int  checks = 0, fails = 0;
   bit  finished = 1'b0;

   // model state
   logic [ADDR_W-1:0] m_addr = '0;
   bit                m_dm = 1'b0, m_half = 1'b0, m_cap = 1'b0;
   logic [BUS_W-1:0]  m_obuf = '0;
   logic [7:0]        m_lo = '0;

   always #2.5 clk = ~clk;

   hmap_port #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .PM_W(PM_W), .PM_DEPTH(DEPTH),
               .DM_DEPTH(DEPTH), .FETCH_LAT(LAT)) i_hmap_port (
      .clk(clk), .rst_n(rst_n), .host_sel_n(host_sel_n), .host_rd_n(host_rd_n),
      .host_wr_n(host_wr_n), .host_latch(host_latch), .host_ad_in(host_ad_in),
      .host_ad_out(host_ad_out), .host_ad_oe(host_ad_oe), .host_ack_n(host_ack_n),
      .core_ctl_we(core_ctl_we), .core_ctl_wdata(core_ctl_wdata),
      .core_mem_we(core_mem_we), .core_mem_pm(core_mem_pm),
      .core_mem_addr(core_mem_addr), .core_mem_wdata(core_mem_wdata)
   );

   function automatic logic [15:0] dm_pat(input int i);
      return 16'(i * 16'h0931 + 16'h5A0C);
   endfunction
   function automatic logic [23:0] pm_pat(input int i);
      return 24'(i * 24'h0A3517 + 24'h3C0F81);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp_v);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
      end
   endtask

   function automatic void m_ctl(input logic [15:0] w);
      if (m_half) begin m_half = 1'b0; m_cap = 1'b1; end
      m_addr = w[13:0];
      m_dm   = w[14];
   endfunction

   function automatic logic [15:0] m_read();
      logic [15:0] prev, nxt;
      logic [23:0] pw;
      prev = m_obuf;
      if (m_dm) begin
         nxt = dm_pat(int'(m_addr) % DEPTH);
         m_addr = m_addr + 1'b1;
      end else if (!m_half) begin
         pw = pm_pat(int'(m_addr) % DEPTH);
         nxt = pw[23:8];
         m_lo = pw[7:0];
         m_half = 1'b1;
      end else begin
         nxt = {m_lo, 8'h00};
         m_half = 1'b0;
         m_addr = m_addr + 1'b1;
      end
      m_obuf = nxt;
      return prev;
   endfunction

   task automatic host_read(input string req, input int hold_extra);
      logic [15:0] exp_d;
      int n;
      while (host_ack_n) @(negedge clk);
      host_sel_n = 1'b0; host_rd_n = 1'b0;
      @(negedge clk);
      chk(host_ack_n == 1'b1, "R2 ack high after accept", int'(host_ack_n), 1);
      chk(host_ad_oe == 1'b1, "R3 drive enable during read", int'(host_ad_oe), 1);
      exp_d = m_read();
      chk(host_ad_out == exp_d, req, int'(host_ad_out), int'(exp_d));
      n = 0;
      while (host_ack_n && n < 100) begin n++; @(negedge clk); end
      chk(n == LAT, "R2 fetch length", n, LAT);
      for (int k = 0; k < hold_extra; k++) begin
         @(negedge clk);
         chk(host_ack_n == 1'b0, "R7 no refetch while strobes held", int'(host_ack_n), 0);
      end
      host_sel_n = 1'b1; host_rd_n = 1'b1;
      @(negedge clk);
      chk(host_ad_oe == 1'b0, "R3 drive enable released", int'(host_ad_oe), 0);
   endtask

   task automatic host_latch_word(input logic [15:0] w);
      host_latch = 1'b1; host_ad_in = w;
      @(negedge clk);
      host_latch = 1'b0;
      m_ctl(w);
      @(negedge clk);
   endtask

   task automatic host_write(input logic [15:0] w);
      host_sel_n = 1'b0; host_wr_n = 1'b0; host_ad_in = w;
      @(negedge clk);
      host_sel_n = 1'b1; host_wr_n = 1'b1;
      if (m_cap) begin
         m_addr = w[13:0]; m_dm = w[14]; m_cap = 1'b0;
      end
      @(negedge clk);
   endtask

   task automatic core_ctl(input logic [15:0] w);
      core_ctl_we = 1'b1; core_ctl_wdata = w;
      @(negedge clk);
      core_ctl_we = 1'b0;
      m_ctl(w);
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(5ns * 150000);
      checks++; fails++;
      $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1 during reset
      chk(host_ack_n == 1'b0, "R1 ack in reset", int'(host_ack_n), 0);
      chk(host_ad_oe == 1'b0, "R1 oe in reset", int'(host_ad_oe), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(host_ack_n == 1'b0, "R1 ack after reset", int'(host_ack_n), 0);
      chk(host_ad_out == 16'h0, "R1 buffer after reset", int'(host_ad_out), 0);

      // fill both memories through the core port
      for (int i = 0; i < DEPTH; i++) begin
         core_mem_we = 1'b1; core_mem_addr = ADDR_W'(i);
         core_mem_pm = 1'b1; core_mem_wdata = pm_pat(i);
         @(negedge clk);
         core_mem_pm = 1'b0; core_mem_wdata = {8'h00, dm_pat(i)};
         @(negedge clk);
      end
      core_mem_we = 1'b0;

      // R4/R5: data memory sweep from 0, first read is the dummy
      host_latch_word(16'h4000);
      host_read("R4 dummy read returns stale buffer", 0);
      for (int i = 0; i < DEPTH; i++) host_read("R5 data sweep", 0);

      // R5/R8: 14-bit wrap, bit 15 ignored
      host_latch_word(16'hFFFE);
      for (int i = 0; i < 5; i++) host_read("R5 address wrap", 0);

      // R6: program memory sweep, two halves per word, wraps index
      host_latch_word(16'h0000);
      for (int i = 0; i < 2*DEPTH + 1; i++) host_read("R6 program halves", 0);

      // R7: strobes held after completion
      host_read("R7 held strobes", 3);
      host_read("R7 next read after release", 0);

      // R8: core control write, then same-cycle priority
      core_ctl(16'h4005);
      for (int i = 0; i < 3; i++) host_read("R8 core control load", 0);
      host_latch = 1'b1; host_ad_in = 16'h4009;
      core_ctl_we = 1'b1; core_ctl_wdata = 16'h4003;
      @(negedge clk);
      host_latch = 1'b0; core_ctl_we = 1'b0;
      m_ctl(16'h4003);
      @(negedge clk);
      for (int i = 0; i < 3; i++) host_read("R8 core write wins over latch", 0);

      // R10: host write with no loss pending
      host_write(16'h4001);
      for (int i = 0; i < 3; i++) host_read("R10 plain host write ignored", 0);

      // R9: loss through host latch, then capturing host write
      host_latch_word(16'h0002);
      host_read("R9 first half before loss", 0);
      host_latch_word(16'h0004);
      host_read("R9 read after latch loss", 0);
      host_write(16'h400A);
      for (int i = 0; i < 3; i++) host_read("R9 control from host write", 0);

      // R9: loss through core write, then R10 write ignored afterwards
      host_latch_word(16'h0001);
      host_read("R9 first half before core loss", 0);
      core_ctl(16'h4000);
      host_write(16'h0006);
      for (int i = 0; i < 3; i++) host_read("R9 control from host write after core loss", 0);
      host_write(16'h4008);
      for (int i = 0; i < 3; i++) host_read("R10 write after capture ignored", 0);

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule